// File: doc/BRIEF.md
# Graphics Port Request Enqueue Front-End

This block collects address requests issued by a graphics bus master and places them in a small request queue for the memory side to consume. A master can hand over requests in one of two ways. In the first, it holds an active-low pipe strobe and puts a full 32-bit address, with a 4-bit command, on the shared address/data lines every clock. In the second, it sends the request over a separate 8-bit sideband bus as a short byte frame. Only one of the two ways is in force at a time.

After reset, configuration software writes a mode word. This word selects the request path, says whether the newer low-swing signaling is in use, and sets a lock bit. Once the lock is set, the mode stays fixed until the next reset. No request is captured before the lock is set. Under the newer signaling the pipe pin carries a bus-inversion flag, so the block does not treat it as a request source. The queue side has a valid/ready handshake, full and empty flags, and two sticky error bits: one for requests lost to a full queue and one for pipe strobes seen in a mode that forbids them.

Top module: `gpq_front`

## Requirements
- R1: When the mode is locked, the pipelined path is selected and the older signaling is in use, every rising clock edge with `pipe_n` low enqueues one entry holding `ad_bus` as the address and `cbe_bus` as the command.
- R2: A clock edge with `pipe_n` high enqueues nothing from `ad_bus`.
- R3: A write on `cfg_wr` loads `cfg_wdata` (bit 0 = sideband path, bit 1 = newer signaling, bit 2 = lock) only while the lock is clear. After the lock is set, writes have no effect until reset. Nothing is enqueued while the lock is clear.
- R4: In sideband mode, a frame starts on a byte whose bit 7 is 0. Bits 3:0 of that byte are the command. The next four bytes are the address, most significant byte first. The entry is enqueued at the edge that captures the fourth address byte.
- R5: When the pipelined path is selected, sideband bytes are ignored. In sideband mode, an idle all-ones bus (lines pulled high) never starts a frame.
- R6: Under the newer signaling, `pipe_n` low never enqueues a request.
- R7: When the mode is locked and `pipe_n` is low while either the sideband path or the newer signaling is selected, `proto_err` is set and stays set until reset. No entry is enqueued.
- R8: The queue holds 8 entries and delivers them in arrival order. `fifo_empty` is high with no entries and `fifo_full` is high with 8.
- R9: A request that arrives while the queue is full and no entry leaves in the same cycle is dropped, and `ovf_err` is set until reset. If an entry leaves in the same cycle, the request is accepted.
- R10: An entry leaves the queue on an edge where `out_valid` and `out_ready` are both high. `out_valid` equals not-empty.
- R11: After reset the queue is empty, both error bits are clear and the mode word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Mode word write strobe |
| cfg_wdata | input | 3 | Mode word: sideband, newer signaling, lock |
| pipe_n | input | 1 | Active-low pipelined request strobe |
| ad_bus | input | 32 | Address lines for pipelined requests |
| cbe_bus | input | 4 | Command lines for pipelined requests |
| sb_bus | input | 8 | Sideband byte lane, idles at all ones |
| out_valid | output | 1 | Queue head holds a request |
| out_ready | input | 1 | Consumer takes the head this clock |
| out_addr | output | 32 | Address at the queue head |
| out_cmd | output | 4 | Command at the queue head |
| fifo_full | output | 1 | Queue holds 8 entries |
| fifo_empty | output | 1 | Queue holds no entries |
| ovf_err | output | 1 | Sticky: a request was dropped |
| proto_err | output | 1 | Sticky: pipe strobe in a forbidden mode |
| mode_sb | output | 1 | Locked-in sideband path selection |
| mode_gen_new | output | 1 | Newer signaling selected |
| mode_locked | output | 1 | Mode word is locked |

## Verification
The case that needs the most care is an enqueue and a dequeue landing on the same edge while the queue is full. If the block tests fullness before it takes the dequeue into account, it drops a request it should have kept. The table-driven part of the bench fills the queue to 8 and then asserts `pipe_n` with `out_ready` high. On the next cycle it expects `fifo_full` still set, `ovf_err` still clear, and the new address to come out later in arrival order. The next row repeats the strobe without `out_ready` and expects the request to be dropped and `ovf_err` to rise.

// File: rtl/gpq_pkg.sv
package gpq_pkg;
  // bit positions inside the mode word written through cfg_wdata
  localparam int CFG_SB   = 0;
  localparam int CFG_GEN  = 1;
  localparam int CFG_LOCK = 2;
  localparam int CFG_W    = 3;

  typedef struct packed {
    logic lock;
    logic gen_new;
    logic sb_sel;
  } gpq_mode_t;

  function automatic gpq_mode_t mode_from_word(input logic [CFG_W-1:0] w);
    gpq_mode_t m;
    m.sb_sel  = w[CFG_SB];
    m.gen_new = w[CFG_GEN];
    m.lock    = w[CFG_LOCK];
    return m;
  endfunction
endpackage

// File: rtl/gpq_cfg.sv
module gpq_cfg
  import gpq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output gpq_mode_t        mode
);
  logic      wr_take;
  gpq_mode_t mode_q;

  assign wr_take = wr && !mode_q.lock;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_take) mode_q <= mode_from_word(wdata);
  end

  assign mode = mode_q;

  // R3: a locked mode word never changes
  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.lock |=> $stable(mode_q));
endmodule

// File: rtl/gpq_pipe_cap.sv
module gpq_pipe_cap #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              sb_sel,
  input  logic              gen_new,
  input  logic              pipe_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [CMD_W-1:0]  cmd_in,
  output logic              push,
  output logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd,
  output logic              proto_hit
);
  logic strobe_on, path_legal;

  assign strobe_on  = locked && !pipe_n;
  assign path_legal = !sb_sel && !gen_new;
  assign push       = strobe_on && path_legal;
  assign proto_hit  = strobe_on && !path_legal;
  assign addr       = ad_in;
  assign cmd        = cmd_in;

  // R6: newer signaling never yields a pipelined request
  a_r6_gen_new_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    gen_new |-> !push);
  // R2: released strobe yields no request
  a_r2_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_n |-> !push);
endmodule

// File: rtl/gpq_sb_cap.sv
module gpq_sb_cap #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int SB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SB_W-1:0]   sb_bus,
  output logic              push,
  output logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd
);
  localparam int BEATS  = ADDR_W / SB_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int ACC_W  = ADDR_W - SB_W;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic              busy;
  logic [BEAT_W-1:0] beat;
  logic [ACC_W-1:0]  acc;
  logic [CMD_W-1:0]  cmd_q;
  logic              start, last_beat;

  function automatic logic [ADDR_W-1:0] sb_shift(input logic [ACC_W-1:0] a,
                                                 input logic [SB_W-1:0] b);
    return {a, b};
  endfunction

  assign start     = en && !busy && !sb_bus[SB_W-1];
  assign last_beat = busy && (beat == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy  <= 1'b0;
      beat  <= '0;
      acc   <= '0;
      cmd_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      beat  <= '0;
      cmd_q <= sb_bus[CMD_W-1:0];
    end else if (busy) begin
      acc  <= sb_shift(acc, sb_bus)[ACC_W-1:0];
      beat <= beat + 1'b1;
      if (last_beat) busy <= 1'b0;
    end
  end

  assign push = en && last_beat;
  assign addr = sb_shift(acc, sb_bus);
  assign cmd  = cmd_q;

  // R5: disabled sideband lane holds the frame engine idle
  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  // R4: a frame occupies exactly BEATS clocks after its header
  a_r4_frame_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last_beat) |=> !busy);
endmodule

// File: rtl/gpq_fifo.sv
module gpq_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  output logic         drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop_ok, accept;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign pop_ok = pop && !empty;
  assign accept = push && (!full || pop_ok);
  assign drop   = push && !accept;
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok) rd_ptr <= ptr_inc(rd_ptr);
      count <= cnt_next(count, accept, pop_ok);
    end
  end

  // R8: occupancy never exceeds the depth
  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R9: a request at full without a dequeue leaves the queue full
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  // R10: a lone dequeue lowers occupancy by one
  a_r10_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/gpq_front.sv
module gpq_front
  import gpq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int SB_W   = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              pipe_n,
  input  logic [ADDR_W-1:0] ad_bus,
  input  logic [CMD_W-1:0]  cbe_bus,
  input  logic [SB_W-1:0]   sb_bus,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CMD_W-1:0]  out_cmd,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              ovf_err,
  output logic              proto_err,
  output logic              mode_sb,
  output logic              mode_gen_new,
  output logic              mode_locked
);
  localparam int ENT_W = ADDR_W + CMD_W;

  gpq_mode_t         mode;
  logic              sb_en;
  logic              p_push, p_proto, s_push, q_push, q_drop;
  logic [ADDR_W-1:0] p_addr, s_addr;
  logic [CMD_W-1:0]  p_cmd, s_cmd;
  logic [ENT_W-1:0]  q_data, q_head;

  gpq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .mode(mode)
  );

  assign sb_en = mode.lock && mode.sb_sel;

  gpq_pipe_cap #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .locked(mode.lock), .sb_sel(mode.sb_sel),
    .gen_new(mode.gen_new), .pipe_n(pipe_n), .ad_in(ad_bus), .cmd_in(cbe_bus),
    .push(p_push), .addr(p_addr), .cmd(p_cmd), .proto_hit(p_proto)
  );

  gpq_sb_cap #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .SB_W(SB_W)) u_sb (
    .clk(clk), .rst_n(rst_n), .en(sb_en), .sb_bus(sb_bus),
    .push(s_push), .addr(s_addr), .cmd(s_cmd)
  );

  assign q_push = p_push || s_push;
  assign q_data = mode.sb_sel ? {s_addr, s_cmd} : {p_addr, p_cmd};

  gpq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(q_data),
    .pop(out_ready), .head(q_head), .full(fifo_full), .empty(fifo_empty),
    .drop(q_drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_err   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (q_drop)  ovf_err   <= 1'b1;
      if (p_proto) proto_err <= 1'b1;
    end
  end

  assign out_valid    = !fifo_empty;
  assign out_addr     = q_head[ENT_W-1:CMD_W];
  assign out_cmd      = q_head[CMD_W-1:0];
  assign mode_sb      = mode.sb_sel;
  assign mode_gen_new = mode.gen_new;
  assign mode_locked  = mode.lock;

  // R7: forbidden strobe raises the protocol flag and never enqueues
  a_r7_proto_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.lock && !pipe_n && (mode.sb_sel || mode.gen_new)) |=> proto_err);
  a_r7_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r7_no_pipe_push: assert property (@(posedge clk) disable iff (!rst_n)
    p_proto |-> !p_push);
  // R9: overflow flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  // R1: an accepted pipelined request leaves the queue non-empty
  a_r1_pipe_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (p_push && !fifo_full) |=> !fifo_empty);
  // R3: unlocked block never enqueues
  a_r3_no_early_push: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.lock |-> !q_push);
  // R5: only one request path can be live
  a_r5_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_push && s_push));
endmodule

// File: tb/sim_gpq_front.sv
`timescale 1ns/1ps
module sim_gpq_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_wdata;
  logic        pipe_n;
  logic [31:0] ad_bus;
  logic [3:0]  cbe_bus;
  logic [7:0]  sb_bus;
  logic        out_valid, out_ready;
  logic [31:0] out_addr;
  logic [3:0]  out_cmd;
  logic        fifo_full, fifo_empty, ovf_err, proto_err;
  logic        mode_sb, mode_gen_new, mode_locked;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  gpq_front u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pipe_n(pipe_n), .ad_bus(ad_bus), .cbe_bus(cbe_bus), .sb_bus(sb_bus),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_cmd(out_cmd), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ovf_err(ovf_err), .proto_err(proto_err), .mode_sb(mode_sb),
    .mode_gen_new(mode_gen_new), .mode_locked(mode_locked)
  );

  // row bits: {pipe_n, out_ready, expected empty, expected full} after the edge
  localparam int NROW = 21;
  localparam logic [3:0] VEC [NROW] = '{
    4'b0000, 4'b0000, 4'b1100, 4'b0100, 4'b0000, 4'b0000, 4'b0000,
    4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0101, 4'b0001, 4'b1100,
    4'b1100, 4'b1100, 4'b1100, 4'b1100, 4'b1100, 4'b1100, 4'b1110
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; cfg_wdata = '0; pipe_n = 1; ad_bus = '0; cbe_bus = '0;
    sb_bus = 8'hFF; out_ready = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cfg_write(input logic [2:0] w);
    cfg_wr = 1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic sb_frame(input logic [3:0] c, input logic [31:0] a);
    sb_bus = {4'b0000, c};  @(negedge clk);
    sb_bus = a[31:24];      @(negedge clk);
    sb_bus = a[23:16];      @(negedge clk);
    sb_bus = a[15:8];       @(negedge clk);
    sb_bus = a[7:0];        @(negedge clk);
    sb_bus = 8'hFF;
  endtask

  logic [35:0] model [$];
  logic        exp_ovf;

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();

    // R11: reset state
    chk("R11 empty", fifo_empty, 1);
    chk("R11 full", fifo_full, 0);
    chk("R11 valid", out_valid, 0);
    chk("R11 ovf", ovf_err, 0);
    chk("R11 proto", proto_err, 0);
    chk("R11 mode", {mode_locked, mode_gen_new, mode_sb}, 3'b000);

    // R3: strobe before lock enqueues nothing and flags nothing
    pipe_n = 0; ad_bus = 32'h1111_2222;
    @(negedge clk);
    pipe_n = 1;
    chk("R3 prelock empty", fifo_empty, 1);
    chk("R3 prelock proto", proto_err, 0);

    // R3: lock pipelined mode, then a later write is ignored
    cfg_write(3'b100);
    chk("R3 locked", {mode_locked, mode_gen_new, mode_sb}, 3'b100);
    cfg_write(3'b011);
    chk("R3 write after lock", {mode_locked, mode_gen_new, mode_sb}, 3'b100);

    // R1 R2 R8 R9 R10: table walk in pipelined mode
    exp_ovf = 0;
    for (int i = 0; i < NROW; i++) begin
      logic do_pop;
      pipe_n    = VEC[i][3];
      out_ready = VEC[i][2];
      ad_bus    = 32'hC0DE_0000 + 32'(i);
      cbe_bus   = 4'(i);
      #1;
      do_pop = out_ready && (model.size() > 0);
      if (do_pop) begin
        chk("R10 head addr", out_addr, model[0][35:4]);
        chk("R8 head cmd", out_cmd, model[0][3:0]);
      end
      if (!pipe_n) begin
        if (model.size() < 8 || do_pop) model.push_back({ad_bus, cbe_bus});
        else exp_ovf = 1;
      end
      if (do_pop) void'(model.pop_front());
      @(negedge clk);
      chk("R8 empty flag", fifo_empty, VEC[i][1]);
      chk("R8 full flag", fifo_full, VEC[i][0]);
      chk("R9 ovf flag", ovf_err, exp_ovf);
      chk("R10 valid", out_valid, !VEC[i][1]);
    end
    pipe_n = 1; out_ready = 0;
    chk("R2 proto clear", proto_err, 0);

    // R5: sideband frame in pipelined mode is ignored
    sb_frame(4'h3, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R5 sb ignored", fifo_empty, 1);

    // R4: sideband mode frame
    do_reset();
    cfg_write(3'b101);
    sb_frame(4'h5, 32'h1234_5678);
    chk("R4 frame valid", out_valid, 1);
    chk("R4 frame addr", out_addr, 32'h1234_5678);
    chk("R4 frame cmd", out_cmd, 4'h5);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk("R10 drained", fifo_empty, 1);
    // R5: all-ones idle never starts a frame
    repeat (8) @(negedge clk);
    chk("R5 idle ones", fifo_empty, 1);
    // R7: strobe in sideband mode
    pipe_n = 0; ad_bus = 32'h5555_AAAA;
    @(negedge clk);
    pipe_n = 1;
    chk("R7 sb proto", proto_err, 1);
    chk("R7 sb no push", fifo_empty, 1);
    @(negedge clk);
    chk("R7 sticky", proto_err, 1);

    // R6: newer signaling with pipelined path
    do_reset();
    cfg_write(3'b110);
    pipe_n = 0; ad_bus = 32'h7777_0000;
    repeat (3) @(negedge clk);
    pipe_n = 1;
    chk("R6 no push", fifo_empty, 1);
    chk("R7 gen proto", proto_err, 1);
    chk("R9 no ovf", ovf_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule